// File: doc/BRIEF.md
# Shared Free-Running Random Source with Eight Permuted Taps

This block holds one 128-bit generator state and advances it on every clock edge, with no enable and no dependence on whoever reads it. Each step produces a 64-bit scrambled word: the low state word times 5, rotated left by 7, then times 9, with all arithmetic modulo 2^64. That word is presented on a raw output. Eight consumer ports each receive 32 bits of the same word. Every port uses its own fixed pattern for picking those bits and putting them in order.

Any consumer may read its port whenever it likes. Because a consumer samples at most once every two clocks, two reads it makes in a row always come from different generator steps. Reset loads the state from a seed input. An all-zero seed would lock the generator, so it is replaced by a fixed non-zero constant.

Top module: `prng_tap_hub`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `raw_o` and every `tap_o` word are zero after that edge.
- R2: Reset loads state word A from `seed_i[63:0]` and state word B from `seed_i[127:64]`. The first `raw_o` value after reset is released is the scramble of the seed's low word.
- R3: An all-zero `seed_i` loads A = 64'hD1B54A32D192ED03 and B = 64'h9E3779B97F4A7C15 instead, so the state is never all zero.
- R4: On each edge out of reset, with t = A ^ B, the next A is rotl(A,24) ^ t ^ (t << 16) and the next B is rotl(t,37).
- R5: On each edge out of reset, `raw_o` takes rotl(A*5, 7)*9 (mod 2^64), computed from A before that edge's update.
- R6: Port k (0..7) occupies `tap_o[32k+31:32k]`. Bit j of that port equals bit ((8k+5)*j + 7k+3) mod 64 of the scrambled word, so each port picks 32 distinct bits and no two ports share a pattern.
- R7: All eight ports and `raw_o` update on the same edge and always reflect the same generator step.
- R8: Asserting reset in the middle of a run restarts the sequence from the seed, exactly as a reset at power-up does.
- R9: `seed_i` has no effect while `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the generator steps on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| seed_i | input | 128 | Seed; bits 127:64 go to state word B, bits 63:0 to state word A |
| raw_o | output | 64 | Registered scrambled word of the current step |
| tap_o | output | 256 | Eight registered 32-bit consumer words; port k is bits 32k+31:32k |

## Verification
Two functions can meet in one cycle. A reset can arrive while the generator is stepping freely, and the seed input can move while the generator runs. The bench changes `seed_i` during free running and then pulls reset low in the middle of a sequence, once with a non-zero seed and once with an all-zero seed. A behavioural model tracks the state and predicts `raw_o` and all eight taps on every clock. The model is judged correct only if it reloads the seed at the reset edge, ignores the seed at every other edge, and puts out zeros during reset.

// File: rtl/prng_pkg.sv
// prng_pkg: shared constants and pure functions for the tap hub.
// Assumes a 64-bit state word and 32-bit taps; all functions are combinational.
package prng_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned ROT_A  = 24;
    localparam int unsigned SHL_B  = 16;
    localparam int unsigned ROT_C  = 37;
    localparam int unsigned MIX_R  = 7;
    localparam logic [WORD_W-1:0] ZSEED_A = 64'hD1B54A32D192ED03;
    localparam logic [WORD_W-1:0] ZSEED_B = 64'h9E3779B97F4A7C15;

    typedef struct packed {
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] a;
    } gen_state_t;

    // Rotate a state word left by a constant amount.
    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                               input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Star-star scrambler: rotl(x*5, 7)*9, modulo 2^64.
    function automatic logic [WORD_W-1:0] star_mix(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] m5;
        m5 = (x << 2) + x;
        m5 = rotl(m5, MIX_R);
        return (m5 << 3) + m5;
    endfunction

    // One generator step.
    function automatic gen_state_t advance(input gen_state_t s);
        gen_state_t        n;
        logic [WORD_W-1:0] t;
        t   = s.a ^ s.b;
        n.a = rotl(s.a, ROT_A) ^ t ^ (t << SHL_B);
        n.b = rotl(t, ROT_C);
        return n;
    endfunction

    // Source bit of the scrambled word for bit j of port k (odd stride => distinct bits).
    function automatic int unsigned tap_src(input int unsigned k, input int unsigned j);
        return ((8 * k + 5) * j + 7 * k + 3) % WORD_W;
    endfunction
endpackage

// File: rtl/prng_seed_sel.sv
// prng_seed_sel: maps the seed input to a legal starting state.
// Assumes nothing about the seed; an all-zero seed is swapped for a fixed constant.
module prng_seed_sel
    import prng_pkg::*;
(
    input  logic [2*WORD_W-1:0] seed_i,
    output gen_state_t          start_o
);
    // Choose the seed or the zero-seed substitute.
    always_comb begin
        if (seed_i == '0) begin
            start_o.a = ZSEED_A;
            start_o.b = ZSEED_B;
        end else begin
            start_o.a = seed_i[WORD_W-1:0];
            start_o.b = seed_i[2*WORD_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/prng_core.sv
// prng_core: holds the 128-bit state, steps it every clock, registers the raw word.
// Assumes a synchronous active-low reset that holds the start state while low.
module prng_core
    import prng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  gen_state_t        start_i,
    output gen_state_t        state_o,
    output logic [WORD_W-1:0] mix_o,
    output logic [WORD_W-1:0] raw_o
);
    gen_state_t        st_q;
    logic [WORD_W-1:0] raw_q;

    // Scramble the current (pre-update) state word A.
    always_comb mix_o = star_mix(st_q.a);

    // Load the seed in reset, otherwise advance one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= start_i;
        else        st_q <= advance(st_q);
    end

    // Register the scrambled word alongside the state update.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= mix_o;
    end

    assign state_o = st_q;
    assign raw_o   = raw_q;
endmodule

// File: rtl/prng_tap.sv
// prng_tap: one consumer port; picks TAP_W bits of the scrambled word in a fixed
// per-port order and registers them. Assumes TAP_W <= WORD_W.
module prng_tap
    import prng_pkg::*;
#(
    parameter int unsigned PORT_ID = 0,
    parameter int unsigned TAP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mix_i,
    output logic [TAP_W-1:0]  tap_o
);
    logic [TAP_W-1:0] pick;
    logic [TAP_W-1:0] tap_q;

    // Fixed wiring from scrambled word bits to port bits.
    for (genvar j = 0; j < TAP_W; j++) begin : g_bit
        localparam int unsigned SRC = tap_src(PORT_ID, j);
        assign pick[j] = mix_i[SRC];
    end

    // Register the port word on the same edge as the raw word.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= pick;
    end

    assign tap_o = tap_q;
endmodule

// File: rtl/prng_tap_hub.sv
// prng_tap_hub: one free-running generator shared by NPORT permuted consumer taps.
// Assumes consumers sample no more often than every second clock.
module prng_tap_hub
    import prng_pkg::*;
#(
    parameter int unsigned NPORT = 8,
    parameter int unsigned TAP_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*WORD_W-1:0]    seed_i,
    output logic [WORD_W-1:0]      raw_o,
    output logic [NPORT*TAP_W-1:0] tap_o
);
    gen_state_t        start;
    gen_state_t        state;
    logic [WORD_W-1:0] mix;

    prng_seed_sel u_seed (
        .seed_i  (seed_i),
        .start_o (start)
    );

    prng_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .state_o (state),
        .mix_o   (mix),
        .raw_o   (raw_o)
    );

    // One registered tap per consumer port.
    for (genvar k = 0; k < NPORT; k++) begin : g_port
        prng_tap #(
            .PORT_ID (k),
            .TAP_W   (TAP_W)
        ) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .mix_i (mix),
            .tap_o (tap_o[k*TAP_W +: TAP_W])
        );
    end
endmodule

// File: rtl/prng_tap_hub_chk.sv
// prng_tap_hub_chk: temporal checks on the hub, bound into every instance.
module prng_tap_hub_chk
    import prng_pkg::*;
#(
    parameter int unsigned NPORT = 8,
    parameter int unsigned TAP_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [WORD_W-1:0]      st_a,
    input logic [WORD_W-1:0]      st_b,
    input logic [WORD_W-1:0]      raw_o,
    input logic [NPORT*TAP_W-1:0] tap_o
);
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw_o == '0 && tap_o == '0));

    assert_state_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_a | st_b) != '0);

    assert_step_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_b == rotl($past(st_a) ^ $past(st_b), ROT_C));

    assert_step_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_a == (rotl($past(st_a), ROT_A) ^ ($past(st_a) ^ $past(st_b))
                                  ^ (($past(st_a) ^ $past(st_b)) << SHL_B)));

    assert_raw_mix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_o == star_mix($past(st_a)));

    // Each tap is a subset of the raw word's bits, so it cannot hold more ones (R7).
    for (genvar k = 0; k < NPORT; k++) begin : g_pc
        assert_tap_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_o[k*TAP_W +: TAP_W]) <= $countones(raw_o));
    end
endmodule

bind prng_tap_hub prng_tap_hub_chk #(.NPORT(NPORT), .TAP_W(TAP_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .st_a  (state.a),
    .st_b  (state.b),
    .raw_o (raw_o),
    .tap_o (tap_o)
);

// File: tb/sim_prng_tap_hub.sv
module sim_prng_tap_hub;
    localparam int NP = 8;
    localparam int TW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [127:0]      seed_i = '0;
    logic [63:0]       raw_o;
    logic [NP*TW-1:0]  tap_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    longint unsigned m_a, m_b, m_raw;

    prng_tap_hub u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed_i),
        .raw_o  (raw_o),
        .tap_o  (tap_o)
    );

    always #4 clk = ~clk;

    function automatic longint unsigned rl(longint unsigned x, int n);
        return (x << n) | (x >> (64 - n));
    endfunction

    // Model one clock edge from the inputs seen at that edge.
    task automatic model_edge(bit rst_low, logic [127:0] sd);
        longint unsigned t;
        if (rst_low) begin
            m_raw = 0;
            if (sd == 0) begin m_a = 64'hD1B54A32D192ED03; m_b = 64'h9E3779B97F4A7C15; end
            else begin m_a = sd[63:0]; m_b = sd[127:64]; end
        end else begin
            m_raw = rl(m_a * 5, 7) * 9;
            t   = m_a ^ m_b;
            m_a = rl(m_a, 24) ^ t ^ (t << 16);
            m_b = rl(t, 37);
        end
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare raw word and all taps against the model (R5, R6, R7).
    task automatic compare(string req);
        logic [31:0] e;
        check(req, raw_o, m_raw);
        for (int k = 0; k < NP; k++) begin
            for (int j = 0; j < TW; j++)
                e[j] = m_raw[((8 * k + 5) * j + 7 * k + 3) % 64];
            check({req, " R6 R7 tap"}, {32'h0, tap_o[k*TW +: TW]}, {32'h0, e});
        end
    endtask

    // Drive inputs at negedge, step model at posedge, sample 2 ns later.
    task automatic cyc(bit rl_low, logic [127:0] sd, string req);
        @(negedge clk);
        rst_n  = !rl_low;
        seed_i = sd;
        @(posedge clk);
        model_edge(rl_low, sd);
        #2;
        compare(req);
    endtask

    initial begin
        // R1, R2: reset with a non-zero seed.
        for (int i = 0; i < 3; i++) cyc(1, 128'h0123456789ABCDEF_FEDCBA9876543210, "R1");
        cyc(0, 128'h0123456789ABCDEF_FEDCBA9876543210, "R2");
        for (int i = 0; i < 150; i++) cyc(0, 128'h0123456789ABCDEF_FEDCBA9876543210, "R4 R5");
        // R9: seed moves while running; model keeps ignoring it.
        for (int i = 0; i < 40; i++) cyc(0, {64'(i) * 64'h1111, 64'hA5A5}, "R9");
        // R8: mid-run reset with a new seed.
        cyc(1, 128'h00000000000000FF_8000000000000001, "R8 R1");
        for (int i = 0; i < 80; i++) cyc(0, 128'h00000000000000FF_8000000000000001, "R8");
        // R3: all-zero seed.
        for (int i = 0; i < 2; i++) cyc(1, '0, "R3 R1");
        for (int i = 0; i < 100; i++) cyc(0, '0, "R3");
        // Single-bit seed in the high word only.
        cyc(1, {64'h1, 64'h0}, "R2");
        for (int i = 0; i < 60; i++) cyc(0, '1, "R2 R9");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule